// File: doc/BRIEF.md
# Board Interrupt Collector

This block gathers board interrupt requests into one line for a host. Eleven ISA-style request lines and five extra board lines become sixteen numbered sources. A rising edge on a source sets its bit in a latched pending vector. The bit stays set until the host acknowledges it. The host sees a single summary interrupt output. It reads the pending vector as two bytes and acknowledges sources by writing ones to the matching bits.

The block sits on a simple 16-bit register bus with an address, read and write strobes, and data. Two status words hold the low and high halves of the pending vector. A write-only control word selects two behaviours:
- Retrigger: the summary line drops for one cycle when a new source arrives while others are still pending. This gives an edge-sampling host a fresh edge.
- Auto-clear: a status read also acknowledges the bits it returned.

The control word also drives two board control outputs. A read-only word reports a packed hardware version byte.

Top module: `irq_collector`

## Requirements
- R1: Bus address bits 2:1 select the word; address bit 0 is ignored. Word 0 (offset 0x0) reads pending sources 7..0 in bits 7:0, and word 2 (offset 0x4) reads pending sources 15..8 in bits 7:0. Read bits 15:8 are zero, and `rd_data` is zero while `rd_en` is low. Source n of the high word sits at bit n-8.
- R2: A pending bit is set by a rising edge of its source, sampled on `clk`. It stays set while the source is held high after an acknowledge, until the next rising edge.
- R3: A write to offset 0x0 clears each pending source 0..7 whose bit is one in `wr_data[7:0]`. A write to offset 0x4 does the same for sources 8..15. A rising edge in the same cycle as its clear leaves the bit set.
- R4: Sources 0..10 come from `isa_req` lines 3, 4, 5, 6, 7, 10, 11, 12, 9, 14 and 15, in that order. Lines 0, 1, 2, 8 and 13 are ignored. `ext_req[k]` feeds source 11+k.
- R5: `irq_summary` is a register that is high exactly when any source is pending, except during a retrigger pulse.
- R6: Control bit 0 is retrigger. When it is set, a source that newly latches while another source stays pending drives `irq_summary` low for exactly one cycle, after which it is high again.
- R7: Control bit 1 is auto-clear. When it is set, a status read clears the bits it returned, so an immediate second read returns zero.
- R8: Offset 0x2 is the control word. `wr_data` bit 2 drives `rst_dis` and bit 3 drives `cf_reset`. A read of offset 0x2 returns zero.
- R9: Offset 0x6 returns the version byte in bits 7:0, packed as `LOGIC_REV` in bits 7:5, `BOARD_VER` in bits 4:3 and `BOARD_ISSUE` in bits 2:0. The defaults give 0xB1.
- R10: After reset, all pending bits, control bits and `irq_summary` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Byte offset of the word within the window |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data (combinational) |
| isa_req | input | 16 | ISA request lines, indexed by line number |
| ext_req | input | 5 | Extra board requests, sources 11..15 |
| irq_summary | output | 1 | Summary interrupt to the host |
| rst_dis | output | 1 | Reset-disable control bit |
| cf_reset | output | 1 | CompactFlash reset control bit |

## Verification
A vector table raises mixed patterns of ISA and extra lines. One pattern raises every line at once. Another raises only the unmapped ISA lines, which shows that they are ignored. The patterns then apply partial acknowledge masks on each byte. The results show whether the line-to-source ordering and the byte split hold, and whether a clear removes exactly the masked bits.

Directed cases cover the following:
- a clear and an edge in the same cycle;
- a level held high through an acknowledge;
- a repeated read with auto-clear;
- a second source arriving with and without retrigger, which separates the one-cycle pulse from a steady summary line.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter logic [2:0] LOGIC_REV   = 3'd5,
  parameter logic [1:0] BOARD_VER   = 2'd2,
  parameter logic [2:0] BOARD_ISSUE = 3'd1,
  parameter int         NSRC        = 16,
  parameter int         NISA        = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic [15:0] isa_req,
  input  logic [4:0]  ext_req,
  output logic        irq_summary,
  output logic        rst_dis,
  output logic        cf_reset
);
  localparam int NEXT = NSRC - NISA;
  localparam logic [4*NISA-1:0] LINE_OF_SRC =
    {4'd15, 4'd14, 4'd9, 4'd12, 4'd11, 4'd10, 4'd7, 4'd6, 4'd5, 4'd4, 4'd3};
  localparam logic [7:0] VERSION = {LOGIC_REV, BOARD_VER, BOARD_ISSUE};

  logic [NSRC-1:0] src, src_q, rise, pend, clr, pend_n;
  logic retrig, aclr, pulse;
  logic sel_lo, sel_ctl, sel_hi, sel_ver;

  for (genvar i = 0; i < NISA; i++) begin : g_isa
    assign src[i] = isa_req[LINE_OF_SRC[4*i +: 4]];
  end
  assign src[NSRC-1:NISA] = ext_req[NEXT-1:0];

  assign sel_lo  = addr[2:1] == 2'd0;
  assign sel_ctl = addr[2:1] == 2'd1;
  assign sel_hi  = addr[2:1] == 2'd2;
  assign sel_ver = addr[2:1] == 2'd3;

  assign rise = src & ~src_q;
  assign clr  = {(wr_en && sel_hi) ? wr_data[7:0] : 8'h00,
                 (wr_en && sel_lo) ? wr_data[7:0] : 8'h00}
              | {(rd_en && aclr && sel_hi) ? pend[15:8] : 8'h00,
                 (rd_en && aclr && sel_lo) ? pend[7:0]  : 8'h00};
  assign pend_n = (pend & ~clr) | rise;
  assign pulse  = retrig && (|(rise & ~pend)) && (|(pend & ~clr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q       <= '0;
      pend        <= '0;
      irq_summary <= 1'b0;
      retrig      <= 1'b0;
      aclr        <= 1'b0;
      rst_dis     <= 1'b0;
      cf_reset    <= 1'b0;
    end else begin
      src_q       <= src;
      pend        <= pend_n;
      irq_summary <= (|pend_n) && !pulse;
      if (wr_en && sel_ctl) begin
        retrig   <= wr_data[0];
        aclr     <= wr_data[1];
        rst_dis  <= wr_data[2];
        cf_reset <= wr_data[3];
      end
    end
  end

  always_comb begin
    rd_data = 16'h0000;
    if (rd_en) begin
      if (sel_lo)  rd_data = {8'h00, pend[7:0]};
      if (sel_hi)  rd_data = {8'h00, pend[15:8]};
      if (sel_ver) rd_data = {8'h00, VERSION};
    end
  end

  logic unused_bits;
  assign unused_bits = ^{addr[0], wr_data[15:8]};
endmodule

module irq_collector_chk #(
  parameter logic [7:0] VER = 8'h00
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        irq_summary,
  input logic [15:0] pend,
  input logic [15:0] rise,
  input logic        retrig
);
  AST_SUMMARY_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_summary |-> (pend != 16'h0)); // R5
  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != 16'h0) |=> ((pend & $past(rise)) == $past(rise))); // R2
  AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[2:1] == 2'd0) |=> ((pend[7:0] & $past(wr_data[7:0] & ~rise[7:0])) == 8'h00)); // R3
  AST_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[2:1] == 2'd2) |=> ((pend[15:8] & $past(wr_data[7:0] & ~rise[15:8])) == 8'h00)); // R3
  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[2:1] == 2'd1) |-> (rd_data == 16'h0000)); // R8
  AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[2:1] == 2'd3) |-> (rd_data == {8'h00, VER})); // R9
  AST_DROP_ONLY_ON_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq_summary) && pend != 16'h0) |-> $past(retrig)); // R6
  AST_UPPER_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_data[15:8] == 8'h00)); // R1
endmodule

bind irq_collector irq_collector_chk #(.VER({LOGIC_REV, BOARD_VER, BOARD_ISSUE})) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .irq_summary(irq_summary),
  .pend(pend), .rise(rise), .retrig(retrig));

// File: tb/test_irq_collector.sv
`timescale 1ns/1ps
module test_irq_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [15:0] isa_req = '0;
  logic [4:0]  ext_req = '0;
  logic        irq_summary, rst_dis, cf_reset;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_collector i_irq_collector (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .isa_req(isa_req), .ext_req(ext_req),
    .irq_summary(irq_summary), .rst_dis(rst_dis), .cf_reset(cf_reset));

  // isa[52:37] ext[36:32] clr_lo[31:24] clr_hi[23:16] exp_lo[15:8] exp_hi[7:0]
  localparam logic [52:0] VEC [6] = '{
    {16'h1008, 5'h00, 8'h00, 8'h00, 8'h81, 8'h00},
    {16'hC200, 5'h01, 8'h00, 8'h02, 8'h00, 8'h0D},
    {16'h2107, 5'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {16'hFFFF, 5'h1F, 8'h0F, 8'hF0, 8'hF0, 8'h0F},
    {16'h0420, 5'h10, 8'h20, 8'h00, 8'h04, 8'h80},
    {16'h08D0, 5'h06, 8'h00, 8'h00, 8'h5A, 8'h30}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic raise(input logic [15:0] isa, input logic [4:0] ext);
    @(negedge clk); isa_req = isa; ext_req = ext;
    @(negedge clk); isa_req = '0; ext_req = '0;
    @(negedge clk);
  endtask

  task automatic clear_all();
    bus_wr(3'd0, 16'h00FF);
    bus_wr(3'd4, 16'h00FF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    bus_rd(3'd0, d); check("R10 low status after reset", d, 16'h0);
    bus_rd(3'd4, d); check("R10 high status after reset", d, 16'h0);
    check("R10 summary after reset", {15'h0, irq_summary}, 16'h0);
    check("R10 control outputs after reset", {14'h0, rst_dis, cf_reset}, 16'h0);

    // R1 R3 R4 R5 table walk
    foreach (VEC[i]) begin
      raise(VEC[i][52:37], VEC[i][36:32]);
      bus_wr(3'd0, {8'h00, VEC[i][31:24]});
      bus_wr(3'd4, {8'h00, VEC[i][23:16]});
      bus_rd(3'd0, d); check($sformatf("R4 R3 vec%0d low", i), d, {8'h00, VEC[i][15:8]});
      bus_rd(3'd5, d); check($sformatf("R1 R4 vec%0d high", i), d, {8'h00, VEC[i][7:0]});
      check($sformatf("R5 vec%0d summary", i), {15'h0, irq_summary},
            {15'h0, (VEC[i][15:0] != 16'h0)});
      clear_all();
      check($sformatf("R5 vec%0d summary cleared", i), {15'h0, irq_summary}, 16'h0);
    end

    // R3 edge wins over a same-cycle clear
    raise(16'h0008, 5'h0);
    @(negedge clk); addr = 3'd0; wr_data = 16'h0001; wr_en = 1'b1; isa_req = 16'h0010;
    @(negedge clk); wr_en = 1'b0; isa_req = '0;
    bus_rd(3'd0, d); check("R3 edge beats clear", d, 16'h0002);
    clear_all();

    // R2 held level does not re-latch
    @(negedge clk); isa_req = 16'h0010;
    @(negedge clk);
    bus_wr(3'd0, 16'h0002);
    bus_rd(3'd0, d); check("R2 held level stays cleared", d, 16'h0);
    @(negedge clk); isa_req = '0;
    @(negedge clk);

    // R7 auto-clear on read
    bus_wr(3'd2, 16'h0002);
    raise(16'h0208, 5'h0);
    bus_rd(3'd0, d); check("R7 first read low", d, 16'h0001);
    bus_rd(3'd0, d); check("R7 second read low", d, 16'h0);
    bus_rd(3'd4, d); check("R7 first read high", d, 16'h0001);
    bus_rd(3'd4, d); check("R7 second read high", d, 16'h0);
    bus_wr(3'd2, 16'h0000);

    // R8 control outputs and readback
    bus_wr(3'd2, 16'h000C);
    check("R8 control outputs set", {14'h0, rst_dis, cf_reset}, 16'h0003);
    bus_rd(3'd2, d); check("R8 control reads zero", d, 16'h0);
    bus_wr(3'd2, 16'h0000);
    check("R8 control outputs cleared", {14'h0, rst_dis, cf_reset}, 16'h0);

    // R9 version
    bus_rd(3'd6, d); check("R9 version byte", d, 16'h00B1);

    // R6 retrigger pulse
    bus_wr(3'd2, 16'h0001);
    @(negedge clk); isa_req = 16'h0008;
    @(negedge clk); check("R6 first source summary", {15'h0, irq_summary}, 16'h1);
    isa_req = 16'h0018;
    @(negedge clk); check("R6 pulse low", {15'h0, irq_summary}, 16'h0);
    @(negedge clk); check("R6 back high", {15'h0, irq_summary}, 16'h1);
    isa_req = '0;
    clear_all();
    bus_wr(3'd2, 16'h0000);

    // R6 without retrigger the line stays high
    @(negedge clk); isa_req = 16'h0008;
    @(negedge clk); isa_req = 16'h0018;
    @(negedge clk); check("R6 no pulse when off", {15'h0, irq_summary}, 16'h1);
    @(negedge clk); check("R6 steady when off", {15'h0, irq_summary}, 16'h1);
    isa_req = '0;
    clear_all();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule